// File: doc/BRIEF.md
# Clock domain source-select divider

This block produces the clock for one clock domain. It picks one of five incoming source clocks through a glitch-free selector, then divides the picked clock by a ratio given as two phase counts. The first count sets how many source cycles the output stays high. The second sets how many cycles it stays low. A bypass control passes the picked clock through without division.

Software reaches the block through a single 32-bit configuration word. A write updates the word, and the word is read back continuously on `rd_data`. A new ratio is committed by setting a self-clearing request bit together with the new counts. The divider picks up the new counts only when a low phase ends, so no period is ever cut short. A status bit shows whether a source change is still under way.

Two parameters select a narrower variant. `CNT_W` narrows the counts to 3 bits. `FIXED_SRC` pins the selector to the third source input.

Top module: `clkdom_divsel`

## Requirements
- R1: Field [2:0] selects the source: code n (0 to 4) routes `src_clk[n]` to the divider. After reset, source 0 is selected and the field reads 0.
- R2: A write whose [2:0] code is 5, 6 or 7 leaves the selected source unchanged. Readback keeps the previous code and the output keeps its period.
- R3: Bit 3 reads 1 from the cycle after a write that changes the selection until the new source drives the output, and 0 otherwise. No two source enables are ever on together. No output pulse is shorter than the high or low phase of the source in use.
- R4: In divide mode the output period is (W + H + 2) source cycles. The output is high for W + 1 cycles and low for H + 1 cycles.
- R5: The high-phase count W is held in bits [19:16] and the low-phase count H in bits [23:20]. Both are 0 after reset.
- R6: A write with bit 25 set stores new W and H and makes bit 25 read 1. The hardware clears bit 25 once the new counts are in use. While bit 25 is 1, the W and H fields of further writes are ignored.
- R7: With bit 24 set, the output equals the selected source clock, and W and H have no effect on it. Entering or leaving bypass takes effect at a period boundary.
- R8: With `FIXED_SRC` = 1, the selector always uses source 2. The [2:0] field reads 2 whatever is written to it.
- R9: With `CNT_W` = 3, only the low 3 bits of each count field are stored and the upper field bit reads 0, giving a maximum ratio of 16. With `CNT_W` = 4 the maximum ratio is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register interface clock |
| rst | input | 1 | Active-high reset, synchronous to `clk` |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Registered readback of the configuration word and status |
| src_clk | input | NUM_SRC | Candidate source clocks |
| dom_clk | output | 1 | Divided or bypassed domain clock |

## Verification
The assertions rely on two conditions. Every source clock must keep toggling, because the enable handshake for a source advances only on that source's own falling edges. Reset must also be held long enough for every source to see at least one edge. The bench meets both with five free-running sources of distinct periods and a 20-cycle reset. It changes the selection only after the busy bit has cleared, and it writes new counts during a pending update only to test that such writes are ignored. Output periods and high times are measured in time and compared against the source period multiplied by the programmed counts. A monitor records the narrowest output pulse across every switch and every bypass transition.

// File: rtl/clkdom_pkg.sv
package clkdom_pkg;
  localparam int SEL_LSB  = 0;
  localparam int SEL_W    = 3;
  localparam int BUSY_BIT = 3;
  localparam int HI_LSB   = 16;
  localparam int LO_LSB   = 20;
  localparam int FIELD_W  = 4;
  localparam int BYP_BIT  = 24;
  localparam int UPD_BIT  = 25;
endpackage

// File: rtl/clkdom_cfg.sv
module clkdom_cfg
  import clkdom_pkg::*;
#(
  parameter int NUM_SRC   = 5,
  parameter int CNT_W     = 4,
  parameter bit FIXED_SRC = 1'b0,
  parameter int FIXED_IDX = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic [NUM_SRC-1:0] en_vec,
  input  logic               upd_ack,
  output logic [SEL_W-1:0]   sel_q,
  output logic [CNT_W-1:0]   hi_cnt_q,
  output logic [CNT_W-1:0]   lo_cnt_q,
  output logic               byp_q,
  output logic               upd_req,
  output logic [31:0]        rd_data
);
  localparam logic [SEL_W-1:0] RST_SEL = FIXED_SRC ? SEL_W'(FIXED_IDX) : '0;

  logic [SEL_W-1:0]   wr_sel;
  logic               sel_ok;
  logic [NUM_SRC-1:0] en_s1, en_s2, want;
  logic               ack_s1, ack_s2, pend_q, busy;
  logic [31:0]        rd_next;
  logic               unused_bits;

  assign wr_sel      = wr_data[SEL_LSB +: SEL_W];
  assign sel_ok      = !FIXED_SRC && (int'(wr_sel) < NUM_SRC);
  assign want        = NUM_SRC'(1) << sel_q;
  assign busy        = (en_s2 != want);
  assign unused_bits = ^{wr_data[31:26], wr_data[15:SEL_W], wr_data[HI_LSB +: FIELD_W],
                         wr_data[LO_LSB +: FIELD_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_s1 <= '0; en_s2 <= '0; ack_s1 <= 1'b0; ack_s2 <= 1'b0;
    end else begin
      en_s1 <= en_vec; en_s2 <= en_s1; ack_s1 <= upd_ack; ack_s2 <= ack_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= RST_SEL;
      hi_cnt_q <= '0;
      lo_cnt_q <= '0;
      byp_q    <= 1'b0;
      pend_q   <= 1'b0;
      upd_req  <= 1'b0;
    end else begin
      if (pend_q && (ack_s2 == upd_req)) pend_q <= 1'b0;
      if (wr_en) begin
        if (sel_ok) sel_q <= wr_sel;
        byp_q <= wr_data[BYP_BIT];
        if (!pend_q) begin
          hi_cnt_q <= wr_data[HI_LSB +: CNT_W];
          lo_cnt_q <= wr_data[LO_LSB +: CNT_W];
          if (wr_data[UPD_BIT]) begin
            pend_q  <= 1'b1;
            upd_req <= ~upd_req;
          end
        end
      end
    end
  end

  always_comb begin
    rd_next                       = '0;
    rd_next[SEL_LSB +: SEL_W]     = sel_q;
    rd_next[BUSY_BIT]             = busy;
    rd_next[HI_LSB +: FIELD_W]    = FIELD_W'(hi_cnt_q);
    rd_next[LO_LSB +: FIELD_W]    = FIELD_W'(lo_cnt_q);
    rd_next[BYP_BIT]              = byp_q;
    rd_next[UPD_BIT]              = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R2
  bad_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_sel) >= NUM_SRC) |=> $stable(sel_q));

  // R6
  upd_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[UPD_BIT] && !pend_q) |=> pend_q);

  // R6
  pend_counts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && $past(pend_q)) |-> ($stable(hi_cnt_q) && $stable(lo_cnt_q)));

  // R3
  en_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(en_vec));

  generate
    if (FIXED_SRC) begin : g_fixed_chk
      // R8
      fixed_src_chk: assert property (@(posedge clk) disable iff (rst)
        sel_q == SEL_W'(FIXED_IDX));
    end
  endgenerate
endmodule

// File: rtl/clkdom_switch.sv
module clkdom_switch #(
  parameter int NUM_SRC = 5,
  parameter int SEL_W   = 3
) (
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_SRC-1:0] en_vec,
  output logic               mux_clk
);
  logic [NUM_SRC-1:0] gated;

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_src
      logic req, s1, s2;
      // a source may arm only when it is selected and every other enable is off
      assign req = (sel == SEL_W'(i)) && ((en_vec & ~(NUM_SRC'(1) << i)) == '0);
      always_ff @(negedge src_clk[i] or posedge rst) begin
        if (rst) begin
          s1 <= 1'b0; s2 <= 1'b0;
        end else begin
          s1 <= req; s2 <= s1;
        end
      end
      assign en_vec[i] = s2;
      assign gated[i]  = src_clk[i] & s2;
    end
  endgenerate

  assign mux_clk = |gated;
endmodule

// File: rtl/clkdom_div.sv
module clkdom_div #(
  parameter int CNT_W = 4
) (
  input  logic             rst,
  input  logic             mux_clk,
  input  logic [CNT_W-1:0] hi_cfg,
  input  logic [CNT_W-1:0] lo_cfg,
  input  logic             byp_cfg,
  input  logic             upd_req,
  output logic             upd_ack,
  output logic             dom_clk
);
  logic             req_s1, req_s2, byp_s1, byp_s2;
  logic             hi_q, byp_act, seen_q, take;
  logic [CNT_W-1:0] cnt_q, hi_act, lo_act;

  assign take = (req_s2 != upd_ack);

  always_ff @(posedge mux_clk or posedge rst) begin
    if (rst) begin
      req_s1 <= 1'b0; req_s2 <= 1'b0; byp_s1 <= 1'b0; byp_s2 <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      req_s1 <= upd_req; req_s2 <= req_s1; byp_s1 <= byp_cfg; byp_s2 <= byp_s1;
      seen_q <= 1'b1;
    end
  end

  always_ff @(posedge mux_clk or posedge rst) begin
    if (rst) begin
      hi_q    <= 1'b0;
      cnt_q   <= '0;
      hi_act  <= '0;
      lo_act  <= '0;
      byp_act <= 1'b0;
      upd_ack <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (hi_q) begin
      hi_q  <= 1'b0;
      cnt_q <= lo_act;
    end else begin
      // end of the low phase: the only point where settings change
      hi_q    <= 1'b1;
      byp_act <= byp_s2;
      if (take) begin
        cnt_q   <= hi_cfg;
        hi_act  <= hi_cfg;
        lo_act  <= lo_cfg;
        upd_ack <= req_s2;
      end else begin
        cnt_q <= hi_act;
      end
    end
  end

  assign dom_clk = byp_act ? mux_clk : hi_q;

  // R4
  cnt_bound_chk: assert property (@(posedge mux_clk) disable iff (rst)
    cnt_q <= (hi_q ? hi_act : lo_act));

  // R7
  byp_boundary_chk: assert property (@(posedge mux_clk) disable iff (rst)
    (seen_q && !$stable(byp_act)) |-> $rose(hi_q));

  // R6
  ack_boundary_chk: assert property (@(posedge mux_clk) disable iff (rst)
    (seen_q && !$stable(upd_ack)) |-> $rose(hi_q));
endmodule

// File: rtl/clkdom_divsel.sv
module clkdom_divsel
  import clkdom_pkg::*;
#(
  parameter int NUM_SRC   = 5,
  parameter int CNT_W     = 4,
  parameter bit FIXED_SRC = 1'b0,
  parameter int FIXED_IDX = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic [NUM_SRC-1:0] src_clk,
  output logic               dom_clk
);
  logic [SEL_W-1:0]   sel;
  logic [CNT_W-1:0]   hi_cnt, lo_cnt;
  logic               byp, upd_req, upd_ack, mux_clk;
  logic [NUM_SRC-1:0] en_vec;

  clkdom_cfg #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .FIXED_SRC(FIXED_SRC), .FIXED_IDX(FIXED_IDX)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .en_vec(en_vec),
    .upd_ack(upd_ack), .sel_q(sel), .hi_cnt_q(hi_cnt), .lo_cnt_q(lo_cnt),
    .byp_q(byp), .upd_req(upd_req), .rd_data(rd_data)
  );

  clkdom_switch #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sw (
    .rst(rst), .src_clk(src_clk), .sel(sel), .en_vec(en_vec), .mux_clk(mux_clk)
  );

  clkdom_div #(.CNT_W(CNT_W)) u_div (
    .rst(rst), .mux_clk(mux_clk), .hi_cfg(hi_cnt), .lo_cfg(lo_cnt), .byp_cfg(byp),
    .upd_req(upd_req), .upd_ack(upd_ack), .dom_clk(dom_clk)
  );
endmodule

// File: tb/sim_clkdom_divsel.sv
`timescale 1ns/1ps
module sim_clkdom_divsel;
  logic        clk = 1'b0, rst = 1'b1;
  logic        wr0 = 1'b0, wr1 = 1'b0;
  logic [31:0] wd0 = '0, wd1 = '0, rd0, rd1;
  logic [4:0]  src = '0;
  logic        o0, o1;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  real         last_edge = 0.0, min_pulse = 1.0e9;

  always #4 clk = ~clk;
  always #5  src[0] = ~src[0];
  always #7  src[1] = ~src[1];
  always #3  src[2] = ~src[2];
  always #11 src[3] = ~src[3];
  always #9  src[4] = ~src[4];

  clkdom_divsel u0 (.clk(clk), .rst(rst), .wr_en(wr0), .wr_data(wd0), .rd_data(rd0),
                    .src_clk(src), .dom_clk(o0));
  clkdom_divsel #(.CNT_W(3), .FIXED_SRC(1'b1), .FIXED_IDX(2)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr1), .wr_data(wd1), .rd_data(rd1),
    .src_clk(src), .dom_clk(o1));

  // narrowest pulse seen on the main output after reset
  always @(o0) begin
    if (!rst && last_edge > 0.0 && ($realtime - last_edge) < min_pulse)
      min_pulse = $realtime - last_edge;
    if (!rst) last_edge = $realtime;
  end

  function automatic logic [31:0] mk(int sel, int hc, int lc, bit byp, bit upd);
    logic [31:0] w = '0;
    w[2:0] = 3'(sel); w[19:16] = 4'(hc); w[23:20] = 4'(lc); w[24] = byp; w[25] = upd;
    return w;
  endfunction

  task automatic chk_i(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_r(string req, real act, real exp);
    checks++;
    if (act < exp - 0.1 || act > exp + 0.1) begin
      errors++;
      $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic write(int which, logic [31:0] d);
    @(negedge clk);
    if (which == 0) begin wr0 = 1'b1; wd0 = d; end else begin wr1 = 1'b1; wd1 = d; end
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic read(int which, output logic [31:0] d);
    @(negedge clk);
    @(negedge clk);
    d = (which == 0) ? rd0 : rd1;
  endtask

  task automatic poll_clear(int which, int bitpos, string req);
    int n = 0;
    logic [31:0] d;
    do begin
      @(negedge clk);
      d = (which == 0) ? rd0 : rd1;
      n++;
    end while (d[bitpos] && n < 3000);
    chk_i(req, int'(d[bitpos]), 0);
  endtask

  task automatic measure(int which, output real per, output real hi);
    real t0, t1, t2;
    for (int k = 0; k < 2; k++) begin
      if (which == 0) begin
        @(posedge o0); t0 = $realtime; @(negedge o0); t1 = $realtime; @(posedge o0); t2 = $realtime;
      end else begin
        @(posedge o1); t0 = $realtime; @(negedge o1); t1 = $realtime; @(posedge o1); t2 = $realtime;
      end
    end
    per = t2 - t0; hi = t1 - t0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    poll_clear(0, 3, "R3 busy after reset");
    read(0, d);
    chk_i("R1 reset select", int'(d[2:0]), 0);
    chk_i("R5 reset counts", int'(d[23:16]), 0);
    read(1, d);
    chk_i("R8 fixed reset select", int'(d[2:0]), 2);
  endtask

  task automatic t_ratio;
    logic [31:0] d;
    real per, hi;
    write(0, mk(0, 2, 3, 0, 1));
    read(0, d);
    chk_i("R6 update bit set", int'(d[25]), 1);
    poll_clear(0, 25, "R6 update bit clears");
    read(0, d);
    chk_i("R5 high count field", int'(d[19:16]), 2);
    chk_i("R5 low count field", int'(d[23:20]), 3);
    measure(0, per, hi);
    chk_r("R4 period 7x10", per, 70.0);
    chk_r("R4 high 3x10", hi, 30.0);
  endtask

  task automatic t_formula;
    real per, hi;
    // ratio 9: high count 9/2-1 = 3, low count 9-3-2 = 4
    write(0, mk(0, 3, 4, 0, 1));
    poll_clear(0, 25, "R6 update clears ratio 9");
    measure(0, per, hi);
    chk_r("R4 period ratio 9", per, 90.0);
    chk_r("R4 high ratio 9", hi, 40.0);
  endtask

  task automatic t_switch;
    logic [31:0] d;
    real per, hi;
    write(0, mk(2, 3, 4, 0, 0));
    read(0, d);
    chk_i("R3 busy during switch", int'(d[3]), 1);
    poll_clear(0, 3, "R3 busy clears");
    read(0, d);
    chk_i("R1 select reads 2", int'(d[2:0]), 2);
    measure(0, per, hi);
    chk_r("R1 period on source 2", per, 54.0);
  endtask

  task automatic t_invalid;
    logic [31:0] d;
    real per, hi;
    write(0, mk(6, 3, 4, 0, 0));
    read(0, d);
    chk_i("R2 code 6 ignored", int'(d[2:0]), 2);
    chk_i("R2 no busy on code 6", int'(d[3]), 0);
    measure(0, per, hi);
    chk_r("R2 period kept", per, 54.0);
  endtask

  task automatic t_pending;
    logic [31:0] d;
    real per, hi;
    write(0, mk(2, 1, 1, 0, 1));
    write(0, mk(2, 5, 5, 0, 0));
    poll_clear(0, 25, "R6 update clears");
    read(0, d);
    chk_i("R6 counts kept while pending", int'(d[23:16]), 8'h11);
    measure(0, per, hi);
    chk_r("R6 period 4x6", per, 24.0);
  endtask

  task automatic t_bypass;
    real per, hi;
    write(0, mk(2, 1, 1, 1, 0));
    repeat (40) @(negedge clk);
    measure(0, per, hi);
    chk_r("R7 bypass period", per, 6.0);
    chk_r("R7 bypass high", hi, 3.0);
    write(0, mk(2, 6, 6, 1, 1));
    poll_clear(0, 25, "R6 update in bypass");
    measure(0, per, hi);
    chk_r("R7 counts no effect", per, 6.0);
    write(0, mk(2, 6, 6, 0, 0));
    repeat (40) @(negedge clk);
    measure(0, per, hi);
    chk_r("R7 leave bypass period", per, 84.0);
  endtask

  task automatic t_max;
    real per, hi;
    write(0, mk(4, 15, 15, 0, 1));
    poll_clear(0, 3, "R3 busy to source 4");
    poll_clear(0, 25, "R9 update max");
    measure(0, per, hi);
    chk_r("R9 max ratio 32 period", per, 576.0);
    chk_r("R9 max ratio high", hi, 288.0);
    write(0, mk(1, 0, 0, 0, 1));
    poll_clear(0, 3, "R3 busy to source 1");
    poll_clear(0, 25, "R4 update ratio 2");
    measure(0, per, hi);
    chk_r("R4 ratio 2 period", per, 28.0);
    chk_r("R4 ratio 2 high", hi, 14.0);
  endtask

  task automatic t_fixed;
    logic [31:0] d;
    real per, hi;
    write(1, mk(0, 7, 7, 0, 1));
    read(1, d);
    chk_i("R8 select write ignored", int'(d[2:0]), 2);
    poll_clear(1, 25, "R8 update clears");
    measure(1, per, hi);
    chk_r("R9 narrow max period 16x6", per, 96.0);
    write(1, mk(4, 15, 15, 0, 1));
    poll_clear(1, 25, "R9 update narrow");
    read(1, d);
    chk_i("R9 upper count bit dropped", int'(d[23:16]), 8'h77);
    chk_i("R8 select still 2", int'(d[2:0]), 2);
    measure(1, per, hi);
    chk_r("R9 narrow period kept", per, 96.0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ratio();
    t_formula();
    t_switch();
    t_invalid();
    t_pending();
    t_bypass();
    t_max();
    t_fixed();
    chk_r("R3 narrowest pulse", (min_pulse >= 2.9) ? 3.0 : min_pulse, 3.0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule